// File: doc/BRIEF.md
# Timed Noise Gate Controller

This block decides when a recording channel has gone quiet for long enough to be gated, and what the gate then does to the input gain stage. On each sample strobe it compares a per-sample absolute peak level against a threshold derived from a 5-bit code. The gate closes once the level has stayed below that threshold for a full timeout. A separate, higher reopen level acts as hysteresis, so a signal hovering around the threshold does not make the gate chatter.

When the gate closes, a 2-bit action code chooses what happens. It can freeze the gain stage at its present setting, hard-mute the digital output at once, ramp an attenuation code up to its maximum over the fade time, or ramp and then mute. The action code is captured when the gate closes. The timeout (250 ms by default) and the fade time (100 ms by default) are converted into sample counts from a sample-rate parameter. The default rate gives 12000 and 4800 samples. Level detection and the gain stage itself sit outside the block.

Top module: `noise_gate_ctrl`

## Requirements
- R1: After reset, gain_freeze_o and mute_o are 0 and gain_atten_o is 0.
- R2: The threshold level is thr_i shifted left by LEVEL_W-5. A strobed sample counts as quiet when level_i is strictly below the threshold level. After TIMEOUT_SAMPLES consecutive quiet samples the gate closes. The outputs take the closed-gate value one clock after the strobe of the last quiet sample.
- R3: While the gate is open, a strobed sample with level_i at or above the threshold level restarts the quiet count from zero.
- R4: While the gate is closed, a sample at or above the threshold level but below threshold level plus HYST leaves the gate closed. A sample at or above threshold level plus HYST reopens it, and one clock after that strobe all three outputs are inactive.
- R5: Action code 0 (hold): a closed gate drives gain_freeze_o=1, mute_o=0 and gain_atten_o=0.
- R6: Action code 1 (mute): a closed gate drives mute_o=1, gain_freeze_o=0 and gain_atten_o=0.
- R7: Action code 2 (fade): a closed gate raises gain_atten_o by one every STEP_SAMPLES strobes, where STEP_SAMPLES is FADE_SAMPLES divided by 2^ATT_W-1 with a minimum of 1. Counting starts at the strobe after the closing one. The code stops at 2^ATT_W-1. mute_o stays 0.
- R8: Action code 3 (fade then mute): the code ramps as in R7, and mute_o rises in the same cycle that gain_atten_o reaches 2^ATT_W-1.
- R9: The action code is sampled when the gate closes. Changes to gate_type_i while the gate is closed have no effect until the gate closes again.
- R10: With gate_en_i low, the outputs are inactive from one clock later, the quiet count is cleared, and the gate never closes.
- R11: level_i is ignored in cycles where smp_stb_i is low. Such cycles neither advance nor restart the quiet count.
- R12: With thr_i equal to 0 the gate never closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle strobe marking a valid level sample |
| level_i | input | LEVEL_W | Absolute peak level of the current sample |
| gate_en_i | input | 1 | Gate enable |
| thr_i | input | 5 | Threshold code |
| gate_type_i | input | 2 | Action code: 0 hold, 1 mute, 2 fade, 3 fade then mute |
| gain_freeze_o | output | 1 | Hold the gain stage at its current setting |
| gain_atten_o | output | ATT_W | Attenuation override, 0 none, all ones minimum gain |
| mute_o | output | 1 | Digital hard mute |

## Verification
The assertions assume that smp_stb_i is a clean synchronous pulse and that level_i, thr_i and gate_type_i are stable in any cycle where the strobe is high. The threshold and action code are taken to change only between samples. The stimulus drives every input on the falling edge and raises the strobe for exactly one cycle per sample, with some idle gaps. Threshold and action changes are applied only in cycles with no strobe, so no sample sees a value changing mid-cycle.

// File: rtl/ng_pkg.sv
package ng_pkg;
  typedef enum logic [1:0] {
    GT_HOLD      = 2'd0,
    GT_MUTE      = 2'd1,
    GT_FADE      = 2'd2,
    GT_FADE_MUTE = 2'd3
  } gate_type_e;

  function automatic logic is_fading(gate_type_e t);
    return (t == GT_FADE) || (t == GT_FADE_MUTE);
  endfunction
endpackage

// File: rtl/ng_level_cmp.sv
module ng_level_cmp #(
  parameter int LEVEL_W = 16,
  parameter int THR_W   = 5,
  parameter int HYST    = 256
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [THR_W-1:0]   thr_i,
  output logic               below_o,
  output logic               reopen_o
);
  localparam int SHIFT = LEVEL_W - THR_W;
  localparam logic [LEVEL_W:0] HYST_V = (LEVEL_W+1)'(HYST);

  logic [LEVEL_W:0] thr_lvl, open_lvl, lvl_ext;

  always_comb begin
    thr_lvl  = {1'b0, thr_i, {SHIFT{1'b0}}};
    open_lvl = thr_lvl + HYST_V;
    lvl_ext  = {1'b0, level_i};
    below_o  = lvl_ext < thr_lvl;
    reopen_o = lvl_ext >= open_lvl;
  end
endmodule

// File: rtl/ng_timeout_cnt.sv
module ng_timeout_cnt #(
  parameter int TIMEOUT_SAMPLES = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic run_i,
  input  logic below_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT_SAMPLES > 1) ? $clog2(TIMEOUT_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_SAMPLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = stb_i && run_i && below_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (stb_i) begin
      if (!below_i || expire_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2

  AST_GAP_HOLDS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !stb_i |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/ng_fade_ramp.sv
module ng_fade_ramp #(
  parameter int ATT_W        = 6,
  parameter int STEP_SAMPLES = 76
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [ATT_W-1:0] att_o,
  output logic             full_o
);
  localparam int STEP_W = $clog2(STEP_SAMPLES + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_SAMPLES - 1);

  logic [STEP_W-1:0] step_q;
  logic [ATT_W-1:0]  att_q;

  assign att_o  = att_q;
  assign full_o = &att_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q  <= '0;
      step_q <= '0;
    end else if (clr_i) begin
      att_q  <= '0;
      step_q <= '0;
    end else if (adv_i && !full_o) begin
      if (step_q == STEP_LAST) begin
        step_q <= '0;
        att_q  <= att_q + 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  AST_ATT_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (att_o == $past(att_o)) || (att_o == $past(att_o) + 1'b1)); // R7

  AST_ATT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clr_i |=> full_o); // R7
endmodule

// File: rtl/noise_gate_ctrl.sv
module noise_gate_ctrl
  import ng_pkg::*;
#(
  parameter int LEVEL_W        = 16,
  parameter int ATT_W          = 6,
  parameter int HYST           = 256,
  parameter int SAMPLE_RATE_HZ = 48000,
  parameter int TIMEOUT_MS     = 250,
  parameter int FADE_MS        = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_stb_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               gate_en_i,
  input  logic [4:0]         thr_i,
  input  logic [1:0]         gate_type_i,
  output logic               gain_freeze_o,
  output logic [ATT_W-1:0]   gain_atten_o,
  output logic               mute_o
);
  localparam int TIMEOUT_SAMPLES = SAMPLE_RATE_HZ * TIMEOUT_MS / 1000;
  localparam int FADE_SAMPLES    = SAMPLE_RATE_HZ * FADE_MS / 1000;
  localparam int ATT_MAX         = (1 << ATT_W) - 1;
  localparam int STEP_RAW        = FADE_SAMPLES / ATT_MAX;
  localparam int STEP_SAMPLES    = (STEP_RAW < 1) ? 1 : STEP_RAW;

  logic       below, reopen, expire, full;
  logic       gated_q;
  gate_type_e type_q;
  logic       reopen_evt, fade_clr, fade_adv;

  ng_level_cmp #(.LEVEL_W(LEVEL_W), .THR_W(5), .HYST(HYST)) u_cmp (
    .level_i (level_i),
    .thr_i   (thr_i),
    .below_o (below),
    .reopen_o(reopen)
  );

  ng_timeout_cnt #(.TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (smp_stb_i),
    .run_i   (gate_en_i && !gated_q),
    .below_i (below),
    .expire_o(expire)
  );

  assign reopen_evt = gate_en_i && gated_q && smp_stb_i && reopen;
  assign fade_clr   = !gate_en_i || !gated_q || reopen_evt;
  assign fade_adv   = smp_stb_i && is_fading(type_q);

  ng_fade_ramp #(.ATT_W(ATT_W), .STEP_SAMPLES(STEP_SAMPLES)) u_fade (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (fade_clr),
    .adv_i (fade_adv),
    .att_o (gain_atten_o),
    .full_o(full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gated_q <= 1'b0;
      type_q  <= GT_HOLD;
    end else if (!gate_en_i) begin
      gated_q <= 1'b0;
    end else if (expire) begin
      gated_q <= 1'b1;
      type_q  <= gate_type_e'(gate_type_i);
    end else if (reopen_evt) begin
      gated_q <= 1'b0;
    end
  end

  assign gain_freeze_o = gated_q && (type_q == GT_HOLD);
  assign mute_o = gated_q && ((type_q == GT_MUTE) || ((type_q == GT_FADE_MUTE) && full));

  AST_CLOSE_NEEDS_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gated_q) |-> $past(expire)); // R2

  AST_REOPEN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reopen_evt |=> !mute_o && !gain_freeze_o && (gain_atten_o == '0)); // R4

  AST_EN_LOW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> !mute_o && !gain_freeze_o && (gain_atten_o == '0)); // R10

  AST_HOLD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_freeze_o |-> !mute_o && (gain_atten_o == '0)); // R5

  AST_TYPE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_q && $past(gated_q) |-> $stable(type_q)); // R9

  AST_ZERO_THR_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i == 5'd0) |-> !expire); // R12
endmodule

// File: tb/noise_gate_ctrl_bench.sv
module noise_gate_ctrl_bench;
  localparam int LW    = 16;
  localparam int AW    = 4;
  localparam int HY    = 256;
  localparam int TO    = 200;  // 800 Hz * 250 ms
  localparam int STEP  = 5;    // 80 samples / 15
  localparam int AMAX  = 15;

  typedef struct {
    logic          frz;
    logic [AW-1:0] att;
    logic          mute;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0, stb = 0, en = 1;
  logic [LW-1:0] level = '0;
  logic [4:0] thr = 5'd4;
  logic [1:0] gtype = 2'd0;
  logic frz_o, mute_o;
  logic [AW-1:0] att_o;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t sb[$];

  // reference state
  bit m_gated = 0;
  int m_cnt = 0, m_att = 0, m_st = 0, m_type = 0;

  always #10 clk = ~clk;

  noise_gate_ctrl #(.LEVEL_W(LW), .ATT_W(AW), .HYST(HY), .SAMPLE_RATE_HZ(800),
                    .TIMEOUT_MS(250), .FADE_MS(100)) u_noise_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .level_i(level),
    .gate_en_i(en), .thr_i(thr), .gate_type_i(gtype),
    .gain_freeze_o(frz_o), .gain_atten_o(att_o), .mute_o(mute_o));

  function automatic exp_t model_out(string tag);
    exp_t e;
    e.frz  = m_gated && (m_type == 0);
    e.mute = m_gated && ((m_type == 1) || ((m_type == 3) && (m_att == AMAX)));
    e.att  = AW'(m_att);
    e.tag  = tag;
    return e;
  endfunction

  task automatic model_clear();
    m_gated = 0; m_cnt = 0; m_att = 0; m_st = 0;
  endtask

  task automatic cmp(exp_t e);
    total++;
    if (frz_o !== e.frz || att_o !== e.att || mute_o !== e.mute) begin
      bad++;
      $display("FAIL %s: got frz=%0b att=%0d mute=%0b exp frz=%0b att=%0d mute=%0b",
               e.tag, frz_o, att_o, mute_o, e.frz, e.att, e.mute);
    end
  endtask

  task automatic samp(input logic [LW-1:0] lv, input string tag);
    int tl;
    tl = int'(thr) << (LW - 5);
    if (!en) model_clear();
    else if (!m_gated) begin
      if (int'(lv) < tl) begin
        m_cnt++;
        if (m_cnt == TO) begin
          m_gated = 1; m_cnt = 0; m_att = 0; m_st = 0; m_type = int'(gtype);
        end
      end else m_cnt = 0;
    end else begin
      if (int'(lv) >= tl + HY) model_clear();
      else if (m_type >= 2 && m_att < AMAX) begin
        m_st++;
        if (m_st == STEP) begin m_st = 0; m_att++; end
      end
    end
    sb.push_back(model_out(tag));
    @(negedge clk); stb = 1; level = lv;
    @(negedge clk); stb = 0;
  endtask

  task automatic run(int n, input logic [LW-1:0] lv, input string tag);
    for (int i = 0; i < n; i++) samp(lv, tag);
  endtask

  task automatic set_en(logic v);
    @(negedge clk); en = v;
    if (!v) model_clear();
    @(negedge clk);
    cmp(model_out("R10 enable"));
  endtask

  // monitor: compare after each strobed edge
  always @(posedge clk) begin
    if (rst_n && stb) begin
      #2;
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: got frz=%0b att=%0d mute=%0b exp none", frz_o, att_o, mute_o);
      end else cmp(sb.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp(model_out("R1 reset"));
    rst_n = 1;
    @(negedge clk);
    cmp(model_out("R1 after release"));

    // R2 + R5: hold action, threshold 4 -> level 8192
    thr = 5'd4; gtype = 2'd0;
    run(TO - 1, 16'd100, "R2 counting");
    samp(16'd8191, "R2 close R5 hold");
    // R4 hysteresis band keeps gate closed, then reopen
    run(3, 16'd8192 + 16'd100, "R4 band");
    samp(16'd8192 + 16'd255, "R4 band edge");
    samp(16'd8192 + 16'd256, "R4 reopen");

    // R3: sample at threshold restarts the count; R6 mute action
    gtype = 2'd1;
    run(150, 16'd0, "R3 partial");
    samp(16'd8192, "R3 restart");
    run(TO - 1, 16'd0, "R3 still open");
    samp(16'd0, "R3 close R6 mute");
    // R9: type change while closed has no effect
    @(negedge clk); gtype = 2'd0;
    run(10, 16'd50, "R9 latched type");
    samp(16'hFFFF, "R9 reopen");

    // R7 fade only
    gtype = 2'd2;
    run(TO, 16'd10, "R7 close");
    run(AMAX * STEP + 10, 16'd10, "R7 ramp");
    samp(16'd9000, "R7 reopen");

    // R8 fade then mute
    gtype = 2'd3;
    run(TO, 16'd10, "R8 close");
    run(AMAX * STEP + 5, 16'd10, "R8 ramp mute");
    // R10 enable low while gated
    set_en(1'b0);
    run(TO + 20, 16'd0, "R10 disabled");
    set_en(1'b1);

    // R11: idle cycles without strobe ignored
    gtype = 2'd1;
    run(TO - 1, 16'd0, "R11 count");
    @(negedge clk); level = 16'hFFFF;
    repeat (40) @(negedge clk);
    cmp(model_out("R11 idle high level"));
    samp(16'd0, "R11 close");
    samp(16'hFFFF, "R11 reopen");

    // R12: zero threshold never closes
    thr = 5'd0;
    run(TO + 50, 16'd0, "R12 zero thr");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d left exp 0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule